// File: doc/BRIEF.md
# Masked Channel Request Priority Encoder

This block sits between the per-channel request sources of a multi-channel DMA controller and its transfer sequencer. For every channel it merges a hardware request line and a software request bit. It gates both with that channel's mask bit and its two-bit transfer mode, which yields an effective request vector. A fixed-priority encoder, with channel 0 highest, reduces that vector to a one-hot winner, a binary winner index and a flag that says whether channel 0 is the current winner. The OR of all effective requests becomes the pending signal. The sequencer uses pending to raise its bus hold request.

The software request bits live in a small register inside the block. Per-channel set and clear pulses write it, and a master-clear pulse empties all of it. When the sequencer leaves idle it raises `svc_active`. On the first clock edge that samples it high, the block captures the live winner. It holds that selection unchanged for as long as `svc_active` stays high, so request lines changing in mid-service cannot redirect the acknowledge. The channel count is a parameter. `rst_n` is expected to be asserted asynchronously and already released in step with `clk`.

Top module: `dma_req_arbiter`

## Requirements
- R1: A channel whose `chan_mask` bit is 1 never contributes to `pend` and never wins, whatever its hardware or software request. A mask bit of 0 leaves the channel eligible.
- R2: A software request bit counts as a request only while that channel's mode field (`chan_mode[2i+1:2i]`) is 2'b10 (block). In every other mode it has no effect on the outputs.
- R3: `master_clr` empties every software request bit on the next edge. A `sw_clr` bit empties its channel's bit on the next edge and takes precedence over a simultaneous `sw_set`. Without either, `sw_set` sets the bit.
- R4: Mode 2'b11 (cascade) never lets the channel win, from either request source. Hardware requests count in modes 2'b00, 2'b01 and 2'b10.
- R5: The winner is the lowest-numbered channel with an effective request. `live_onehot` has exactly that bit set and `live_idx` holds its number. Both are zero when nothing is pending.
- R6: `pend` is high exactly when at least one channel has an effective request.
- R7: `ch0_top` is high exactly when channel 0 is the current winner.
- R8: On the first rising edge that samples `svc_active` high, `sel_onehot`, `sel_idx` and `sel_valid` take the live winner and pending value. They then stay unchanged while `svc_active` remains high, whatever the requests do.
- R9: The edge after `svc_active` is sampled low clears `sel_onehot`, `sel_idx` and `sel_valid` to zero.
- R10: After reset all software request bits are zero and `sel_onehot`, `sel_idx` and `sel_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| hw_req | input | NCH | Hardware request line per channel |
| chan_mask | input | NCH | Per-channel mask, 1 = masked |
| chan_mode | input | 2*NCH | Two mode bits per channel: 00 demand, 01 single, 10 block, 11 cascade |
| sw_set | input | NCH | Pulse: set the channel's software request bit |
| sw_clr | input | NCH | Pulse: clear the channel's software request bit |
| master_clr | input | 1 | Pulse: clear all software request bits |
| svc_active | input | 1 | High while the sequencer is out of idle |
| pend | output | 1 | Any effective request present |
| live_onehot | output | NCH | One-hot live winner |
| live_idx | output | $clog2(NCH) | Index of the live winner |
| ch0_top | output | 1 | Channel 0 is the live winner |
| sel_onehot | output | NCH | One-hot selection held for the service |
| sel_idx | output | $clog2(NCH) | Index held for the service |
| sel_valid | output | 1 | A request was pending when the selection was captured |

## Verification
With four channels, the combinational path is swept over every combination of hardware requests, masks and mode fields with the software bits empty. It is then swept over every combination of software bits, masks and modes with the hardware lines low. The first sweep separates mask gating from cascade exclusion and priority order. The second isolates the block-mode condition on software requests. Directed sequences then apply set, clear and master clear pulses at the same edge to separate their precedence. Request changes during a service window show that the captured selection ignores them, and the cycle after the window closes shows the clear.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    MODE_DEMAND  = 2'b00,
    MODE_SINGLE  = 2'b01,
    MODE_BLOCK   = 2'b10,
    MODE_CASCADE = 2'b11
  } xfer_mode_e;
endpackage

// File: rtl/dma_sw_req_reg.sv
module dma_sw_req_reg #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] sw_set,
  input  logic [NCH-1:0] sw_clr,
  input  logic           master_clr,
  output logic [NCH-1:0] sw_q
);
  logic [NCH-1:0] sw_d;

  always_comb begin
    if (master_clr) sw_d = '0;
    else            sw_d = (sw_q | sw_set) & ~sw_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_q <= '0;
    else        sw_q <= sw_d;
  end
endmodule

// File: rtl/dma_req_qualify.sv
module dma_req_qualify
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0]   hw_req,
  input  logic [NCH-1:0]   sw_q,
  input  logic [NCH-1:0]   chan_mask,
  input  logic [2*NCH-1:0] chan_mode,
  output logic [NCH-1:0]   eff_req
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    xfer_mode_e md;
    logic       hw_ok;
    logic       sw_ok;
    assign md      = xfer_mode_e'(chan_mode[2*g +: 2]);
    assign hw_ok   = hw_req[g] && (md != MODE_CASCADE);
    assign sw_ok   = sw_q[g] && (md == MODE_BLOCK);
    assign eff_req[g] = !chan_mask[g] && (hw_ok || sw_ok);
  end
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] eff_req,
  output logic [NCH-1:0] win_onehot,
  output logic [IW-1:0]  win_idx
);
  always_comb begin
    win_onehot = '0;
    win_idx    = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (eff_req[i]) begin
        win_onehot    = '0;
        win_onehot[i] = 1'b1;
        win_idx       = IW'(i);
      end
    end
  end
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   hw_req,
  input  logic [NCH-1:0]   chan_mask,
  input  logic [2*NCH-1:0] chan_mode,
  input  logic [NCH-1:0]   sw_set,
  input  logic [NCH-1:0]   sw_clr,
  input  logic             master_clr,
  input  logic             svc_active,
  output logic             pend,
  output logic [NCH-1:0]   live_onehot,
  output logic [IW-1:0]    live_idx,
  output logic             ch0_top,
  output logic [NCH-1:0]   sel_onehot,
  output logic [IW-1:0]    sel_idx,
  output logic             sel_valid
);
  logic [NCH-1:0] sw_q;
  logic [NCH-1:0] eff_req;
  logic           svc_q;
  logic           cap_en;
  logic           clr_en;
  logic [NCH-1:0] sel_onehot_d;
  logic [IW-1:0]  sel_idx_d;
  logic           sel_valid_d;

  dma_sw_req_reg #(.NCH(NCH)) u_swreg (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_set     (sw_set),
    .sw_clr     (sw_clr),
    .master_clr (master_clr),
    .sw_q       (sw_q)
  );

  dma_req_qualify #(.NCH(NCH)) u_qual (
    .hw_req    (hw_req),
    .sw_q      (sw_q),
    .chan_mask (chan_mask),
    .chan_mode (chan_mode),
    .eff_req   (eff_req)
  );

  dma_prio_pick #(.NCH(NCH)) u_pick (
    .eff_req    (eff_req),
    .win_onehot (live_onehot),
    .win_idx    (live_idx)
  );

  assign pend    = |eff_req;
  assign ch0_top = eff_req[0];

  // capture on entry into service, clear once service has ended
  assign cap_en = svc_active && !svc_q;
  assign clr_en = !svc_active;

  always_comb begin
    sel_onehot_d = sel_onehot;
    sel_idx_d    = sel_idx;
    sel_valid_d  = sel_valid;
    if (cap_en) begin
      sel_onehot_d = live_onehot;
      sel_idx_d    = live_idx;
      sel_valid_d  = pend;
    end else if (clr_en) begin
      sel_onehot_d = '0;
      sel_idx_d    = '0;
      sel_valid_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_q      <= 1'b0;
      sel_onehot <= '0;
      sel_idx    <= '0;
      sel_valid  <= 1'b0;
    end else begin
      svc_q      <= svc_active;
      sel_onehot <= sel_onehot_d;
      sel_idx    <= sel_idx_d;
      sel_valid  <= sel_valid_d;
    end
  end
endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk #(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   chan_mask,
  input logic [2*NCH-1:0] chan_mode,
  input logic             master_clr,
  input logic             svc_active,
  input logic [NCH-1:0]   sw_q,
  input logic             pend,
  input logic [NCH-1:0]   live_onehot,
  input logic [IW-1:0]    live_idx,
  input logic             ch0_top,
  input logic [NCH-1:0]   sel_onehot,
  input logic             sel_valid
);
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (live_onehot & chan_mask) == '0); // R1
  AST_MCLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    master_clr |=> (sw_q == '0)); // R3
  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(live_onehot)); // R5
  AST_PEND_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    pend == (live_onehot != '0)); // R6
  AST_CH0_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ch0_top == (pend && live_idx == '0)); // R7
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_active && (sel_valid || sel_onehot != '0)) |=> (!svc_active || $stable(sel_onehot))); // R8
  AST_SEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !svc_active |=> (sel_onehot == '0 && !sel_valid)); // R9

  for (genvar g = 0; g < NCH; g++) begin : g_casc
    AST_CASCADE_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_mode[2*g +: 2] == 2'b11) |-> !live_onehot[g]); // R4
  end
endmodule

bind dma_req_arbiter dma_arb_chk #(.NCH(NCH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .chan_mask   (chan_mask),
  .chan_mode   (chan_mode),
  .master_clr  (master_clr),
  .svc_active  (svc_active),
  .sw_q        (sw_q),
  .pend        (pend),
  .live_onehot (live_onehot),
  .live_idx    (live_idx),
  .ch0_top     (ch0_top),
  .sel_onehot  (sel_onehot),
  .sel_valid   (sel_valid)
);

// File: tb/sim_dma_req_arbiter.sv
module sim_dma_req_arbiter;
  localparam int NCH = 4;
  localparam int IW  = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NCH-1:0]   hw_req;
  logic [NCH-1:0]   chan_mask;
  logic [2*NCH-1:0] chan_mode;
  logic [NCH-1:0]   sw_set;
  logic [NCH-1:0]   sw_clr;
  logic             master_clr;
  logic             svc_active;
  logic             pend;
  logic [NCH-1:0]   live_onehot;
  logic [IW-1:0]    live_idx;
  logic             ch0_top;
  logic [NCH-1:0]   sel_onehot;
  logic [IW-1:0]    sel_idx;
  logic             sel_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dma_req_arbiter #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .chan_mask(chan_mask),
    .chan_mode(chan_mode), .sw_set(sw_set), .sw_clr(sw_clr),
    .master_clr(master_clr), .svc_active(svc_active), .pend(pend),
    .live_onehot(live_onehot), .live_idx(live_idx), .ch0_top(ch0_top),
    .sel_onehot(sel_onehot), .sel_idx(sel_idx), .sel_valid(sel_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // next posedge, then settle away from it
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // model: effective requests from the requirement text
  function automatic logic [NCH-1:0] eff_model(input logic [NCH-1:0] hw, input logic [NCH-1:0] sw,
                                              input logic [NCH-1:0] msk, input logic [2*NCH-1:0] md);
    logic [NCH-1:0] e;
    for (int i = 0; i < NCH; i++) begin
      logic [1:0] m;
      m = md[2*i +: 2];
      e[i] = !msk[i] && ((hw[i] && m != 2'b11) || (sw[i] && m == 2'b10));
    end
    return e;
  endfunction

  // packed view {pend, ch0_top, idx, onehot} for one compare
  function automatic logic [31:0] exp_pack(input logic [NCH-1:0] e);
    logic [NCH-1:0] oh;
    logic [IW-1:0]  ix;
    oh = '0;
    ix = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (e[i]) begin
        oh = '0;
        oh[i] = 1'b1;
        ix = IW'(i);
      end
    end
    return {24'd0, (|e), e[0], ix, oh};
  endfunction

  function automatic logic [31:0] act_pack();
    return {24'd0, pend, ch0_top, live_idx, live_onehot};
  endfunction

  task automatic load_sw(input logic [NCH-1:0] v);
    master_clr = 1'b1;
    tick();
    master_clr = 1'b0;
    sw_set = v;
    tick();
    sw_set = '0;
  endtask

  initial begin
    #150000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hw_req = '0; chan_mask = '0; chan_mode = '0;
    sw_set = '0; sw_clr = '0; master_clr = 1'b0; svc_active = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    // R10: reset state; block mode everywhere exposes any stray software bit
    chan_mode = 8'hAA;
    #1;
    chk("R10 sel_onehot", sel_onehot, 0);
    chk("R10 sel_idx", sel_idx, 0);
    chk("R10 sel_valid", sel_valid, 0);
    chk("R10 sw bits idle", pend, 0);
    rst_n = 1'b1;
    tick();

    // Sweep A (R1 R4 R5 R6 R7): hw x mask x mode, software empty
    for (int h = 0; h < 16; h++)
      for (int k = 0; k < 16; k++)
        for (int m = 0; m < 256; m++) begin
          hw_req = h[3:0]; chan_mask = k[3:0]; chan_mode = m[7:0];
          #1;
          chk("R1/R4/R5/R6/R7 hw sweep", act_pack(),
              exp_pack(eff_model(h[3:0], 4'd0, k[3:0], m[7:0])));
        end
    hw_req = '0;

    // Sweep B (R2 R1 R5): sw x mask x mode, hardware low
    for (int s = 0; s < 16; s++) begin
      load_sw(s[3:0]);
      for (int k = 0; k < 16; k++)
        for (int m = 0; m < 256; m++) begin
          chan_mask = k[3:0]; chan_mode = m[7:0];
          #1;
          chk("R2 sw sweep", act_pack(),
              exp_pack(eff_model(4'd0, s[3:0], k[3:0], m[7:0])));
        end
    end

    // R3: clear beats set at the same edge; set alone sets
    chan_mask = '0; chan_mode = 8'hAA;
    load_sw(4'b0000);
    sw_set = 4'b0110; sw_clr = 4'b0100;
    tick();
    sw_set = '0; sw_clr = '0;
    #1;
    chk("R3 clear wins over set", live_onehot, 4'b0010);
    sw_set = 4'b1000;
    tick();
    sw_set = '0;
    sw_clr = 4'b0010;
    tick();
    sw_clr = '0;
    #1;
    chk("R3 sw_clr single bit", live_onehot, 4'b1000);
    master_clr = 1'b1; sw_set = 4'b0001;
    tick();
    master_clr = 1'b0; sw_set = '0;
    #1;
    chk("R3 master_clr empties", pend, 0);

    // R8: capture on entry, hold against request changes
    chan_mode = 8'h00; hw_req = 4'b0100;
    svc_active = 1'b1;
    tick();
    chk("R8 captured onehot", sel_onehot, 4'b0100);
    chk("R8 captured idx", sel_idx, 2);
    chk("R8 captured valid", sel_valid, 1);
    hw_req = 4'b0001;
    tick();
    chk("R8 live moved", live_onehot, 4'b0001);
    chk("R8 held onehot", sel_onehot, 4'b0100);
    hw_req = 4'b0000;
    tick();
    chk("R8 held idx", sel_idx, 2);
    chk("R8 held valid", sel_valid, 1);

    // R9: clear after service ends
    svc_active = 1'b0;
    hw_req = 4'b1000;
    tick();
    chk("R9 cleared onehot", sel_onehot, 0);
    chk("R9 cleared idx", sel_idx, 0);
    chk("R9 cleared valid", sel_valid, 0);

    // R8: capture with nothing pending
    hw_req = '0;
    svc_active = 1'b1;
    tick();
    chk("R8 empty capture valid", sel_valid, 0);
    hw_req = 4'b0010;
    tick();
    chk("R8 empty capture held", sel_onehot, 0);
    svc_active = 1'b0;
    tick();
    // R8: new service after a gap captures the new winner
    svc_active = 1'b1;
    tick();
    chk("R8 recapture idx", sel_idx, 1);
    svc_active = 1'b0;
    tick();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule